// File: doc/BRIEF.md
# Multiplex Section Remote Indication Generator

This block produces the two remote-indication fields that the transmit side of an STM-1 multiplex section sends back toward the far end. The first is the remote defect indication, carried in the three low bits of K2. The second is the remote error indication, carried in the M1 byte. The block takes receive-side defect flags that are already integrated, a per-frame count of B2 errors, and three control bits. It turns these into a K2 code and an M1 value once per frame.

Remote defect is raised when any of three causes is present. The first is a received MS-AIS. The second is an excessive error defect, which counts only when its trigger is enabled. The third is a software force. The remote error field carries the B2 error count, clamped to five bits, with the top three bits of M1 tied to zero. When error reporting is switched off, M1 is zero.

Both outputs are loaded on a one-cycle frame-start strobe and then hold for the rest of the frame. Frame assembly uses them at that point.

Top module: `ms_remote_ind_gen`

## Requirements
- R1: While reset is active (rst_n low at a clock edge), both outputs clear: tx_k2_rdi becomes 3'b000 and tx_m1 becomes 8'h00.
- R2: On a frame-start edge, a receive MS-AIS gives tx_k2_rdi = 3'b110 from the next cycle on.
- R3: On a frame-start edge, an excessive error defect gives tx_k2_rdi = 3'b110 when cfg_eed_en is 1. When cfg_eed_en is 0 the defect is ignored, so with no other cause tx_k2_rdi = 3'b000.
- R4: On a frame-start edge, cfg_rdi_force = 1 gives tx_k2_rdi = 3'b110 whatever the receive flags are.
- R5: On a frame-start edge with no active cause, tx_k2_rdi = 3'b000. No code other than 3'b000 or 3'b110 ever appears.
- R6: On a frame-start edge with cfg_rei_en = 1 and a count of 31 or less, tx_m1[4:0] equals that count.
- R7: On a frame-start edge with cfg_rei_en = 1 and a count above 31, tx_m1[4:0] = 5'd31.
- R8: On a frame-start edge with cfg_rei_en = 0, tx_m1 = 8'h00 whatever the count is.
- R9: tx_m1[7:5] is always 3'b000.
- R10: In a cycle without frame_start, tx_k2_rdi and tx_m1 keep their values on the next cycle, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that loads both outputs |
| rx_ms_ais | input | 1 | Receive MS-AIS detected for the past frame |
| rx_eed | input | 1 | Receive excessive error defect |
| b2_err_cnt | input | CNT_W | B2 errors counted in the past frame |
| cfg_rdi_force | input | 1 | Force remote defect |
| cfg_eed_en | input | 1 | Let the excessive error defect raise remote defect |
| cfg_rei_en | input | 1 | Report B2 errors in M1 (0 gives M1 = 0) |
| tx_k2_rdi | output | 3 | K2 bits 2..0 for transmission |
| tx_m1 | output | 8 | M1 byte for transmission |

## Verification
The bench builds the block with CNT_W = 8. This lets the count input go well past the five-bit field. So the bench can drive the exact boundary values 31 and 32, and the top value 255, and compare them against the clamp. It also drives each remote-defect cause alone and in combination, including a masked defect alongside a forced one. Between strobes it changes every input to show that the outputs hold.

// File: rtl/mri_pkg.sv
// Package: shared constants for the remote indication generator.
// Assumes: K2 bits 2..0 and M1 layout as used by the multiplex section.
package mri_pkg;
    localparam int K2_RDI_W   = 3;
    localparam int M1_W       = 8;
    localparam int REI_W      = 5;
    localparam logic [K2_RDI_W-1:0] K2_RDI_ON  = 3'b110;
    localparam logic [K2_RDI_W-1:0] K2_RDI_OFF = 3'b000;
    localparam logic [REI_W-1:0]    REI_MAX    = {REI_W{1'b1}};
endpackage

// File: rtl/mri_rdi_sel.sv
// Module: combines the remote defect causes into the next K2 bits 2..0 code.
// Assumes: inputs are already integrated per frame; purely combinational.
module mri_rdi_sel
    import mri_pkg::*;
(
    input  logic                rx_ms_ais,
    input  logic                rx_eed,
    input  logic                cfg_rdi_force,
    input  logic                cfg_eed_en,
    output logic [K2_RDI_W-1:0] rdi_code
);
    logic eed_cause;
    logic any_cause;

    // Merge the masked defect cause with AIS and the software force.
    always_comb begin
        eed_cause = rx_eed & cfg_eed_en;
        any_cause = rx_ms_ais | eed_cause | cfg_rdi_force;
        rdi_code  = any_cause ? K2_RDI_ON : K2_RDI_OFF;
    end
endmodule

// File: rtl/mri_rei_fmt.sv
// Module: formats the B2 error count into the next M1 byte.
// Assumes: count is unsigned; clamp applies only when CNT_W exceeds the field.
module mri_rei_fmt
    import mri_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] err_cnt,
    input  logic             rei_en,
    output logic [M1_W-1:0]  m1_byte
);
    logic [REI_W-1:0] rei_val;

    generate
        if (CNT_W > REI_W) begin : g_clamp
            localparam logic [CNT_W-1:0] LIMIT = CNT_W'(REI_MAX);
            // Clamp counts that do not fit the five-bit field.
            always_comb begin
                if (err_cnt > LIMIT) rei_val = REI_MAX;
                else                 rei_val = err_cnt[REI_W-1:0];
            end
        end else begin : g_pad
            // Narrow counts always fit; zero-extend them.
            always_comb rei_val = REI_W'(err_cnt);
        end
    endgenerate

    // Upper bits stay zero; the field is suppressed when reporting is off.
    always_comb begin
        m1_byte = '0;
        if (rei_en) m1_byte[REI_W-1:0] = rei_val;
    end
endmodule

// File: rtl/mri_frame_reg.sv
// Module: holds the transmit fields, loading them only on the frame strobe.
// Assumes: frame_start is a single-cycle pulse; synchronous active-low reset.
module mri_frame_reg
    import mri_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [K2_RDI_W-1:0] k2_next,
    input  logic [M1_W-1:0]     m1_next,
    output logic [K2_RDI_W-1:0] k2_q,
    output logic [M1_W-1:0]     m1_q
);
    // Capture the next-frame values at the strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k2_q <= K2_RDI_OFF;
            m1_q <= '0;
        end else if (load) begin
            k2_q <= k2_next;
            m1_q <= m1_next;
        end
    end
endmodule

// File: rtl/ms_remote_ind_gen.sv
// Module: top of the multiplex section remote indication generator.
// Produces K2 bits 2..0 and M1 once per frame from receive defects and B2 count.
// Assumes: all inputs are synchronous to clk and valid at the frame strobe.
module ms_remote_ind_gen
    import mri_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             rx_ms_ais,
    input  logic             rx_eed,
    input  logic [CNT_W-1:0] b2_err_cnt,
    input  logic             cfg_rdi_force,
    input  logic             cfg_eed_en,
    input  logic             cfg_rei_en,
    output logic [2:0]       tx_k2_rdi,
    output logic [7:0]       tx_m1
);
    logic [K2_RDI_W-1:0] k2_next;
    logic [M1_W-1:0]     m1_next;

    mri_rdi_sel u_rdi (
        .rx_ms_ais     (rx_ms_ais),
        .rx_eed        (rx_eed),
        .cfg_rdi_force (cfg_rdi_force),
        .cfg_eed_en    (cfg_eed_en),
        .rdi_code      (k2_next)
    );

    mri_rei_fmt #(.CNT_W(CNT_W)) u_rei (
        .err_cnt (b2_err_cnt),
        .rei_en  (cfg_rei_en),
        .m1_byte (m1_next)
    );

    mri_frame_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_start),
        .k2_next (k2_next),
        .m1_next (m1_next),
        .k2_q    (tx_k2_rdi),
        .m1_q    (tx_m1)
    );
endmodule

// File: rtl/ms_remote_ind_gen_chk.sv
// Checker: temporal properties of the remote indication generator ports.
// Assumes: bound to every instance of ms_remote_ind_gen.
module ms_remote_ind_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             rx_ms_ais,
    input logic             rx_eed,
    input logic [CNT_W-1:0] b2_err_cnt,
    input logic             cfg_rdi_force,
    input logic             cfg_eed_en,
    input logic             cfg_rei_en,
    input logic [2:0]       tx_k2_rdi,
    input logic [7:0]       tx_m1
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (tx_k2_rdi == 3'b000 && tx_m1 == 8'h00));

    assert_ais_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && rx_ms_ais |=> tx_k2_rdi == 3'b110);

    assert_eed_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && rx_eed && !cfg_eed_en && !rx_ms_ais && !cfg_rdi_force
        |=> tx_k2_rdi == 3'b000);

    assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && cfg_rdi_force |=> tx_k2_rdi == 3'b110);

    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_k2_rdi == 3'b000 || tx_k2_rdi == 3'b110);

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && cfg_rei_en && (b2_err_cnt >= CNT_W'(31))
        |=> tx_m1[4:0] == 5'd31);

    assert_rei_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !cfg_rei_en |=> tx_m1 == 8'h00);

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_m1[7:5] == 3'b000);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(tx_k2_rdi) && $stable(tx_m1));
endmodule

bind ms_remote_ind_gen ms_remote_ind_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .rx_ms_ais     (rx_ms_ais),
    .rx_eed        (rx_eed),
    .b2_err_cnt    (b2_err_cnt),
    .cfg_rdi_force (cfg_rdi_force),
    .cfg_eed_en    (cfg_eed_en),
    .cfg_rei_en    (cfg_rei_en),
    .tx_k2_rdi     (tx_k2_rdi),
    .tx_m1         (tx_m1)
);

// File: tb/ms_remote_ind_gen_bench.sv
// Bench: directed scenarios, one task each, checking at the ports.
module ms_remote_ind_gen_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             rx_ms_ais = 1'b0;
    logic             rx_eed = 1'b0;
    logic [CNT_W-1:0] b2_err_cnt = '0;
    logic             cfg_rdi_force = 1'b0;
    logic             cfg_eed_en = 1'b0;
    logic             cfg_rei_en = 1'b0;
    logic [2:0]       tx_k2_rdi;
    logic [7:0]       tx_m1;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    ms_remote_ind_gen #(.CNT_W(CNT_W)) u_ms_remote_ind_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .rx_ms_ais     (rx_ms_ais),
        .rx_eed        (rx_eed),
        .b2_err_cnt    (b2_err_cnt),
        .cfg_rdi_force (cfg_rdi_force),
        .cfg_eed_en    (cfg_eed_en),
        .cfg_rei_en    (cfg_rei_en),
        .tx_k2_rdi     (tx_k2_rdi),
        .tx_m1         (tx_m1)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply inputs, pulse the strobe for one edge, sample after it.
    task automatic frame(input logic ais, input logic eed, input logic frc,
                         input logic eed_en, input logic rei_en, input int cnt);
        @(negedge clk);
        rx_ms_ais = ais; rx_eed = eed; cfg_rdi_force = frc;
        cfg_eed_en = eed_en; cfg_rei_en = rei_en; b2_err_cnt = CNT_W'(cnt);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 k2", {5'd0, tx_k2_rdi}, 8'h00);
        check("R1 m1", tx_m1, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_no_cause;
        frame(0, 0, 0, 1, 0, 0);
        check("R5 idle", {5'd0, tx_k2_rdi}, 8'h00);
    endtask

    task automatic t_ais;
        frame(1, 0, 0, 0, 0, 0);
        check("R2 ais", {5'd0, tx_k2_rdi}, 8'h06);
        frame(0, 0, 0, 0, 0, 0);
        check("R5 cleared", {5'd0, tx_k2_rdi}, 8'h00);
    endtask

    task automatic t_eed;
        frame(0, 1, 0, 1, 0, 0);
        check("R3 eed enabled", {5'd0, tx_k2_rdi}, 8'h06);
        frame(0, 1, 0, 0, 0, 0);
        check("R3 eed masked", {5'd0, tx_k2_rdi}, 8'h00);
    endtask

    task automatic t_force;
        frame(0, 0, 1, 0, 0, 0);
        check("R4 force", {5'd0, tx_k2_rdi}, 8'h06);
        frame(0, 1, 1, 0, 0, 0);
        check("R4 force with masked eed", {5'd0, tx_k2_rdi}, 8'h06);
    endtask

    task automatic t_rei_count;
        frame(0, 0, 0, 0, 1, 0);
        check("R6 zero", tx_m1, 8'h00);
        frame(0, 0, 0, 0, 1, 13);
        check("R6 thirteen", tx_m1, 8'h0D);
        frame(0, 0, 0, 0, 1, 31);
        check("R6 boundary 31", tx_m1, 8'h1F);
    endtask

    task automatic t_saturate;
        frame(0, 0, 0, 0, 1, 32);
        check("R7 32 clamps", tx_m1, 8'h1F);
        frame(0, 0, 0, 0, 1, 255);
        check("R7 255 clamps", tx_m1, 8'h1F);
        check("R9 upper bits", {5'd0, tx_m1[7:5]}, 8'h00);
    endtask

    task automatic t_rei_off;
        frame(0, 0, 0, 0, 0, 200);
        check("R8 disabled big", tx_m1, 8'h00);
        frame(0, 0, 0, 0, 0, 9);
        check("R8 disabled small", tx_m1, 8'h00);
    endtask

    task automatic t_hold;
        frame(1, 0, 0, 0, 1, 7);
        @(negedge clk);
        rx_ms_ais = 0; cfg_rei_en = 0; b2_err_cnt = 8'd100; cfg_rdi_force = 0;
        repeat (4) @(negedge clk);
        check("R10 k2 held", {5'd0, tx_k2_rdi}, 8'h06);
        check("R10 m1 held", tx_m1, 8'h07);
        frame(0, 0, 0, 0, 0, 0);
        check("R10 updates at strobe", tx_m1, 8'h00);
    endtask

    initial begin
        t_reset();
        t_no_cause();
        t_ais();
        t_eed();
        t_force();
        t_rei_count();
        t_saturate();
        t_rei_off();
        t_hold();
        frame(1, 0, 0, 0, 1, 20);
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule